// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block sequences the control steps of a multi-cycle processor. It is built around a micro-program counter (micro-PC). The micro-PC addresses a small internal microcode store. Each microcode word has two parts: a two-bit next-address select and an eight-bit bundle of datapath control points. The control bundle goes straight out of the block for the current step. The select picks where the micro-PC goes on the next clock edge. There are three choices: back to address 0, one step forward, or a jump taken from an opcode-indexed dispatch table.

Address 0 fetches the instruction and address 1 decodes it. The decode step uses the dispatch table to jump into a short execute sequence for the opcode. Each sequence returns to address 0 when it finishes. The datapath and memory sit outside the block; the block only supplies the micro-address and the control word.

Top module: `useq_ctrl`

## Requirements
- R1: Reset is synchronous and active-low. A clock edge with `rst_n` low sets `upc` to 0, even in the middle of an execute sequence. At address 0, `ctrl` reads 0x07.
- R2: When the current word's select is 2'b10, the next edge loads `upc` + 1. Address 0 (fetch) steps to 1, and every multi-step execute sequence advances this way.
- R3: When the select is 2'b01 (used only at address 1), the next edge loads a dispatch target chosen by `opcode` as sampled on that same edge. The targets are: 6'b000000 to 4, 6'b000100 to 3, 6'b001101 to 6, 6'b100011 to 8, and 6'b101011 to 11.
- R4: An opcode not listed in R3 dispatches to address 0, so the machine fetches again.
- R5: When the select is 2'b00, the next edge loads address 0. This ends the sequences at addresses 3, 5, 7 and 10, and applies at the unused addresses 2, 13, 14 and 15.
- R6: The select value 2'b11 is reserved and acts like 2'b00. The last store step, at address 12, uses it and returns to 0.
- R7: `ctrl` follows the micro-address combinationally. Its bits are: bit0 memory read, bit1 instruction-register write, bit2 PC write, bit3 conditional PC write, bit4 immediate ALU operand, bit5 function-decoded ALU operation, bit6 register write, bit7 memory write. The values by address are: 0:0x07, 3:0x08, 4:0x20, 5:0x60, 6:0x30, 7:0x70, 8:0x10, 9:0x11, 10:0x40, 11:0x10, 12:0x90. Every other address gives 0x00. Memory read and memory write are never active together.
- R8: `opcode` has no effect on any edge other than the one leaving address 1. Changing it during fetch or during execute steps leaves the `upc` trajectory unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 6 | Instruction opcode, used on the dispatch edge |
| upc | output | 4 | Current micro-address |
| ctrl | output | 8 | Datapath control word for the current micro-address |

## Verification
The assertions check the next-address rules on every cycle:
- the increment after select 2'b10;
- the return to zero after 2'b00 and 2'b11;
- that a dispatch lands only on a listed target, and on 0 for an unlisted opcode;
- that memory read and write are never active together.

Only the bench's sweep shows the rest. It drives all 64 opcodes through fetch, decode and the full execute sequence. It checks each exact control word and each dispatch target against the table. It also shows that changing the opcode outside the decode edge has no effect, and that a reset in the middle of a sequence takes effect.

// File: rtl/useq_pkg.sv
// Shared widths, select encodings, micro-addresses and opcodes for the
// control sequencer. Assumes a 4-bit micro-PC and a 6-bit opcode.
package useq_pkg;
    localparam int UPC_W  = 4;
    localparam int OP_W   = 6;
    localparam int CTRL_W = 8;
    localparam int SEL_W  = 2;

    typedef logic [UPC_W-1:0]  upc_t;
    typedef logic [OP_W-1:0]   op_t;
    typedef logic [CTRL_W-1:0] ctrl_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_ZERO = 2'b00,
        SEL_DISP = 2'b01,
        SEL_INC  = 2'b10,
        SEL_RSVD = 2'b11
    } nsel_e;

    typedef struct packed {
        nsel_e sel;
        ctrl_t ctrl;
    } uword_t;

    // Entry points of the microprogram
    localparam upc_t UA_FETCH  = 4'd0;
    localparam upc_t UA_DECODE = 4'd1;
    localparam upc_t UA_BEQ    = 4'd3;
    localparam upc_t UA_RTYPE  = 4'd4;
    localparam upc_t UA_ORI    = 4'd6;
    localparam upc_t UA_LOAD   = 4'd8;
    localparam upc_t UA_STORE  = 4'd11;

    // Opcodes that have a dispatch entry
    localparam op_t OP_RTYPE = 6'b000000;
    localparam op_t OP_BEQ   = 6'b000100;
    localparam op_t OP_ORI   = 6'b001101;
    localparam op_t OP_LOAD  = 6'b100011;
    localparam op_t OP_STORE = 6'b101011;
endpackage

// File: rtl/useq_dispatch_rom.sv
// Opcode-to-entry-point lookup used on the decode step.
// Assumes: any opcode without an entry maps to the fetch address.
module useq_dispatch_rom
    import useq_pkg::*;
(
    input  op_t  opcode,
    output upc_t target
);
    // Map the opcode to the first micro-address of its execute sequence
    always_comb begin
        case (opcode)
            OP_RTYPE: target = UA_RTYPE;
            OP_BEQ:   target = UA_BEQ;
            OP_ORI:   target = UA_ORI;
            OP_LOAD:  target = UA_LOAD;
            OP_STORE: target = UA_STORE;
            default:  target = UA_FETCH;
        endcase
    end
endmodule

// File: rtl/useq_ucode_rom.sv
// Microcode store: returns the next-address select and the datapath
// control bundle for one micro-address.
// Assumes: unused words carry select zero and an all-zero bundle.
module useq_ucode_rom
    import useq_pkg::*;
(
    input  upc_t   addr,
    output uword_t word
);
    // Look up the microinstruction at the current address
    always_comb begin
        word = '{sel: SEL_ZERO, ctrl: '0};
        case (addr)
            4'd0:  word = '{sel: SEL_INC,  ctrl: 8'h07}; // fetch
            4'd1:  word = '{sel: SEL_DISP, ctrl: 8'h00}; // decode
            4'd3:  word = '{sel: SEL_ZERO, ctrl: 8'h08}; // branch compare
            4'd4:  word = '{sel: SEL_INC,  ctrl: 8'h20}; // reg-reg ALU
            4'd5:  word = '{sel: SEL_ZERO, ctrl: 8'h60}; // reg-reg writeback
            4'd6:  word = '{sel: SEL_INC,  ctrl: 8'h30}; // or-imm ALU
            4'd7:  word = '{sel: SEL_ZERO, ctrl: 8'h70}; // or-imm writeback
            4'd8:  word = '{sel: SEL_INC,  ctrl: 8'h10}; // load address
            4'd9:  word = '{sel: SEL_INC,  ctrl: 8'h11}; // load read
            4'd10: word = '{sel: SEL_ZERO, ctrl: 8'h40}; // load writeback
            4'd11: word = '{sel: SEL_INC,  ctrl: 8'h10}; // store address
            4'd12: word = '{sel: SEL_RSVD, ctrl: 8'h90}; // store write
            default: word = '{sel: SEL_ZERO, ctrl: 8'h00};
        endcase
    end
endmodule

// File: rtl/useq_next_addr.sv
// Next micro-address selector: zero, dispatch target or increment.
// Assumes: the reserved select code behaves like return-to-zero.
module useq_next_addr
    import useq_pkg::*;
(
    input  nsel_e sel,
    input  upc_t  cur,
    input  upc_t  disp,
    output upc_t  nxt
);
    // Choose the source of the next micro-PC value
    always_comb begin
        case (sel)
            SEL_INC:  nxt = cur + 1'b1;
            SEL_DISP: nxt = disp;
            default:  nxt = UA_FETCH;
        endcase
    end
endmodule

// File: rtl/useq_ctrl.sv
// Microprogrammed control sequencer top. It holds the micro-PC and
// drives the control bundle of the current microinstruction.
// Assumes: opcode is stable around the edge that leaves the decode step.
module useq_ctrl
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   opcode,
    output logic [UPC_W-1:0]  upc,
    output logic [CTRL_W-1:0] ctrl
);
    upc_t   upc_q;
    upc_t   upc_nxt;
    upc_t   disp_tgt;
    uword_t uword;
    nsel_e  nsel;

    useq_ucode_rom u_rom (
        .addr (upc_q),
        .word (uword)
    );

    useq_dispatch_rom u_disp (
        .opcode (opcode),
        .target (disp_tgt)
    );

    assign nsel = uword.sel;

    useq_next_addr u_nxt (
        .sel  (nsel),
        .cur  (upc_q),
        .disp (disp_tgt),
        .nxt  (upc_nxt)
    );

    // Micro-PC register with synchronous active-low clear
    always_ff @(posedge clk) begin
        if (!rst_n) upc_q <= UA_FETCH;
        else        upc_q <= upc_nxt;
    end

    assign upc  = upc_q;
    assign ctrl = uword.ctrl;
endmodule

// File: rtl/useq_ctrl_chk.sv
// Property checker for the control sequencer, bound to the top module.
module useq_ctrl_chk
    import useq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   opcode,
    input logic [UPC_W-1:0]  upc,
    input logic [CTRL_W-1:0] ctrl,
    input logic [SEL_W-1:0]  sel
);
    logic op_listed;
    assign op_listed = (opcode == OP_RTYPE) || (opcode == OP_BEQ) ||
                       (opcode == OP_ORI)   || (opcode == OP_LOAD) ||
                       (opcode == OP_STORE);

    assert_step_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b10) |=> (upc == $past(upc) + 4'd1));

    assert_disp_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b01 && op_listed) |=>
        (upc == UA_BEQ || upc == UA_RTYPE || upc == UA_ORI ||
         upc == UA_LOAD || upc == UA_STORE));

    assert_disp_unlisted_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b01 && !op_listed) |=> (upc == UA_FETCH));

    assert_zero_ret_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b00) |=> (upc == UA_FETCH));

    assert_rsvd_ret_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b11) |=> (upc == UA_FETCH));

    assert_mem_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl[0] && ctrl[7]));
endmodule

bind useq_ctrl useq_ctrl_chk chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (opcode),
    .upc    (upc),
    .ctrl   (ctrl),
    .sel    (nsel)
);

// File: tb/useq_ctrl_tb_top.sv
module useq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'd0;
    logic [3:0] upc;
    logic [7:0] ctrl;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    useq_ctrl dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (opcode),
        .upc    (upc),
        .ctrl   (ctrl)
    );

    // Expected control word per micro-address (R7)
    function automatic logic [7:0] exp_ctrl(input logic [3:0] a);
        case (a)
            4'd0: return 8'h07;   4'd3: return 8'h08;
            4'd4: return 8'h20;   4'd5: return 8'h60;
            4'd6: return 8'h30;   4'd7: return 8'h70;
            4'd8: return 8'h10;   4'd9: return 8'h11;
            4'd10: return 8'h40;  4'd11: return 8'h10;
            4'd12: return 8'h90;
            default: return 8'h00;
        endcase
    endfunction

    // Expected select per micro-address: 0 zero, 1 dispatch, 2 inc, 3 reserved
    function automatic int exp_sel(input logic [3:0] a);
        case (a)
            4'd0, 4'd4, 4'd6, 4'd8, 4'd9, 4'd11: return 2;
            4'd1: return 1;
            4'd12: return 3;
            default: return 0;
        endcase
    endfunction

    // Expected dispatch target (R3, R4)
    function automatic logic [3:0] exp_disp(input logic [5:0] op);
        case (op)
            6'b000000: return 4'd4;
            6'b000100: return 4'd3;
            6'b001101: return 4'd6;
            6'b100011: return 4'd8;
            6'b101011: return 4'd11;
            default:   return 4'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [3:0] eu);
        total++;
        if (upc !== eu || ctrl !== exp_ctrl(eu)) begin
            bad++;
            $display("FAIL %s: upc=%0d ctrl=%02h expected upc=%0d ctrl=%02h",
                     req, upc, ctrl, eu, exp_ctrl(eu));
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        logic [3:0] eu;
        // R1: reset state
        step();
        step();
        check("R1", 4'd0);
        rst_n = 1'b1;

        // Sweep every opcode through fetch, decode and execute
        for (int op = 0; op < 64; op++) begin
            opcode = 6'(op) ^ 6'h15;       // junk during fetch (R8)
            step();
            check("R2", 4'd1);
            opcode = 6'(op);
            step();
            eu = exp_disp(6'(op));
            check(eu == 4'd0 ? "R4" : "R3", eu);
            opcode = 6'(op) ^ 6'h2B;       // junk during execute (R8)
            for (int k = 0; k < 6 && eu != 4'd0; k++) begin
                int s;
                s = exp_sel(eu);
                eu = (s == 2) ? eu + 4'd1 : 4'd0;
                step();
                case (s)
                    2: check("R2_R8", eu);
                    3: check("R6", eu);
                    default: check("R5", eu);
                endcase
            end
        end

        // R1: reset in the middle of a load sequence
        opcode = 6'b100011;
        step(); check("R2", 4'd1);
        step(); check("R3", 4'd8);
        step(); check("R2", 4'd9);
        rst_n = 1'b0;
        step(); check("R1", 4'd0);
        step(); check("R1", 4'd0);
        rst_n = 1'b1;
        step(); check("R2", 4'd1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: upc=%0d expected sequence completion", upc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule